// File: doc/BRIEF.md
# Thermal and Power Supervisor

This block sits in the always-on control logic of a multi-device processing board. It watches the alert lines of five temperature sensors, each of which covers four of the twenty processing devices. At boot the sensors are programmed to raise their alerts once any covered device's junction temperature passes 80 °C. The block stands in for that programming with a single request pulse that it sends after reset. If an alert stays up long enough to count, the block drops the main supply enable by itself. It then records which sensor fired and keeps the fault latched until the host clears it.

The host also gates the main supply for energy saving: it holds a request level high while the unit is in use and drops it when the unit is idle. The host also picks the I/O signalling level, either 3.3 V single-ended or 2.5 V differential. That choice is applied only while the main supply is off. Once every alert has gone quiet, power may return only after a fixed settle delay.

Top module: `thermal_power_supervisor`

## Requirements
- R1: While reset is held, main_pwr_en_o, sensor_init_o, fault_o and io_mode_o are 0, and fault_src_o is 5'b00000.
- R2: After reset is released, sensor_init_o is high for exactly one cycle before boot_done_o rises, and main_pwr_en_o stays 0 until boot_done_o is 1.
- R3: An alert input counts only once its synchronised level has been high for at least qual_len_i+1 consecutive cycles. A shorter pulse leaves fault_src_o at zero and main power unchanged.
- R4: A qualified alert clears main_pwr_en_o at the same clock edge at which fault_o rises, with no host action.
- R5: Bit i of fault_src_o is set when sensor i (alert_i[i]) qualifies. Bits accumulate and fall only on a host clear.
- R6: While fault_o is 1, main_pwr_en_o stays 0 whatever pwr_req_i is. A one-cycle fault_clr_i with no alert qualified clears fault_src_o.
- R7: If fault_clr_i coincides with a sensor whose alert is still qualified, that sensor's bit stays set.
- R8: After the last qualified alert ends, main power may return only after SETTLE_CYCLES cycles (default 32).
- R9: With power permitted, main_pwr_en_o follows pwr_req_i one clock edge later, in both directions.
- R10: io_mode_o (0 = 3.3 V single-ended, 1 = 2.5 V differential) takes the value of io_mode_req_i only while main power is off, and holds its value while it is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alert_i | input | 5 | Asynchronous over-temperature alerts, one per sensor |
| qual_len_i | input | 8 | Extra cycles an alert must persist before it counts |
| pwr_req_i | input | 1 | Host request level for main power |
| fault_clr_i | input | 1 | Host pulse that clears the latched fault |
| io_mode_req_i | input | 1 | Requested I/O level: 0 = 3.3 V single-ended, 1 = 2.5 V differential |
| sensor_init_o | output | 1 | One-cycle request to program the sensors' thresholds |
| boot_done_o | output | 1 | Boot sequence finished |
| main_pwr_en_o | output | 1 | Main supply enable |
| fault_o | output | 1 | Thermal fault latched; flag to the host |
| fault_src_o | output | 5 | Sensors that caused the latched fault |
| io_mode_o | output | 1 | Applied I/O level select |

## Verification
Two events can fall in the same cycle: a host clear and a sensor alert that is still qualified. The bench holds sensor 2's alert high well past its qualification window and pulses fault_clr_i during that time. It then checks that bit 2 of fault_src_o survives and that power stays off. A second clear, sent after the alert has dropped, must empty the vector. A related overlap is a qualified alert arriving while the host keeps requesting power. The bench samples every cycle and expects fault_o and the fall of main_pwr_en_o in the same sample.

// File: rtl/tps_pkg.sv
// Package: shared types and constants of the thermal and power supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package tps_pkg;

    // Boot sequencer states, in the order they are visited.
    typedef enum logic [1:0] {
        BS_HOLD  = 2'd0,
        BS_INIT  = 2'd1,
        BS_WAIT  = 2'd2,
        BS_READY = 2'd3
    } boot_state_t;

    // I/O level encodings driven on io_mode_o.
    localparam logic IO_LVL_3V3_SE   = 1'b0;
    localparam logic IO_LVL_2V5_DIFF = 1'b1;

endpackage

// File: rtl/tps_alert_qual.sv
// Module: tps_alert_qual
// Synchronises one asynchronous sensor alert with two flops. It then counts
// the consecutive cycles that the synchronised level stays high, and reports
// the alert as qualified once the count reaches the programmed threshold.
// Assumes: qual_len_i is quasi-static; the counter saturates at all-ones.
module tps_alert_qual #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alert_i,
    input  logic [QUAL_W-1:0] qual_len_i,
    output logic              sync_o,
    output logic              qual_o
);
    localparam logic [QUAL_W-1:0] CNT_MAX = {QUAL_W{1'b1}};

    logic              meta_q;
    logic              sync_q;
    logic [QUAL_W-1:0] run_q;

    // Two-flop synchroniser for the alert line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= alert_i;
            sync_q <= meta_q;
        end
    end

    // Run-length counter of the synchronised level, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sync_q) begin
            run_q <= '0;
        end else if (run_q != CNT_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Qualification: the level is still high and has persisted long enough.
    always_comb begin
        sync_o = sync_q;
        qual_o = sync_q && (run_q >= qual_len_i);
    end

endmodule

// File: rtl/tps_boot_seq.sv
// Module: tps_boot_seq
// After reset it sends one sensor-programming request. It then waits a fixed
// number of cycles for the sensors to accept their thresholds, and then
// declares boot done, which is what enables power-on.
// Assumes: BOOT_WAIT >= 1.
module tps_boot_seq
    import tps_pkg::*;
#(
    parameter int BOOT_WAIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic sensor_init_o,
    output logic boot_done_o
);
    localparam int WAIT_W = $clog2(BOOT_WAIT + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(BOOT_WAIT - 1);

    boot_state_t       state_q;
    logic [WAIT_W-1:0] wait_q;

    // State register and wait counter of the boot sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_HOLD;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                BS_HOLD: state_q <= BS_INIT;
                BS_INIT: begin
                    state_q <= BS_WAIT;
                    wait_q  <= '0;
                end
                BS_WAIT: begin
                    if (wait_q == WAIT_LAST) begin
                        state_q <= BS_READY;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: state_q <= BS_READY;
            endcase
        end
    end

    // Decoded outputs of the sequence.
    always_comb begin
        sensor_init_o = (state_q == BS_INIT);
        boot_done_o   = (state_q == BS_READY);
    end

endmodule

// File: rtl/tps_power_ctrl.sv
// Module: tps_power_ctrl
// Owns the fault latch, the post-alert settle timer, the main supply enable
// and the applied I/O level. A qualified alert drops power at once. Power
// returns only after boot is done, the fault is cleared, the settle delay
// has run out and the host asks for it.
// Assumes: qual_i is already synchronous to clk.
module tps_power_ctrl #(
    parameter int N_SENS        = 5,
    parameter int SETTLE_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SENS-1:0] qual_i,
    input  logic              boot_done_i,
    input  logic              pwr_req_i,
    input  logic              fault_clr_i,
    input  logic              io_mode_req_i,
    output logic              main_pwr_en_o,
    output logic [N_SENS-1:0] fault_src_o,
    output logic              io_mode_o
);
    localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE_CYCLES);

    logic [N_SENS-1:0] src_q;
    logic [SET_W-1:0]  settle_q;
    logic              pwr_q;
    logic              io_q;
    logic              any_qual;
    logic              permit;

    // Summary of current qualified alerts and the power permission.
    always_comb begin
        any_qual = |qual_i;
        permit   = boot_done_i && !any_qual && (src_q == '0)
                   && (settle_q == '0) && pwr_req_i;
    end

    // Fault source latch: set wins over a coincident clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (fault_clr_i) begin
            src_q <= qual_i;
        end else begin
            src_q <= src_q | qual_i;
        end
    end

    // Settle timer: reloaded while any alert is qualified, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (any_qual) begin
            settle_q <= SET_LOAD;
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
        end
    end

    // Main supply enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b0;
        end else begin
            pwr_q <= permit;
        end
    end

    // Applied I/O level: tracks the request only while power is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_q <= tps_pkg::IO_LVL_3V3_SE;
        end else if (!pwr_q) begin
            io_q <= io_mode_req_i;
        end
    end

    // Output drive.
    always_comb begin
        main_pwr_en_o = pwr_q;
        fault_src_o   = src_q;
        io_mode_o     = io_q;
    end

endmodule

// File: rtl/thermal_power_supervisor.sv
// Module: thermal_power_supervisor
// Top level: one alert qualifier per sensor, the boot sequencer and the
// power controller. It lives on the standby supply and gates the main supply.
// Assumes: a synchronous active-low reset on the standby clock.
module thermal_power_supervisor #(
    parameter int N_SENS        = 5,
    parameter int QUAL_W        = 8,
    parameter int SETTLE_CYCLES = 32,
    parameter int BOOT_WAIT     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SENS-1:0] alert_i,
    input  logic [QUAL_W-1:0] qual_len_i,
    input  logic              pwr_req_i,
    input  logic              fault_clr_i,
    input  logic              io_mode_req_i,
    output logic              sensor_init_o,
    output logic              boot_done_o,
    output logic              main_pwr_en_o,
    output logic              fault_o,
    output logic [N_SENS-1:0] fault_src_o,
    output logic              io_mode_o
);
    logic [N_SENS-1:0] sync_vec;
    logic [N_SENS-1:0] qual_vec;

    // One qualifier per sensor alert line.
    for (genvar s = 0; s < N_SENS; s++) begin : g_sens
        tps_alert_qual #(.QUAL_W(QUAL_W)) i_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .alert_i    (alert_i[s]),
            .qual_len_i (qual_len_i),
            .sync_o     (sync_vec[s]),
            .qual_o     (qual_vec[s])
        );
    end

    tps_boot_seq #(.BOOT_WAIT(BOOT_WAIT)) i_boot (
        .clk           (clk),
        .rst_n         (rst_n),
        .sensor_init_o (sensor_init_o),
        .boot_done_o   (boot_done_o)
    );

    tps_power_ctrl #(.N_SENS(N_SENS), .SETTLE_CYCLES(SETTLE_CYCLES)) i_pwr (
        .clk           (clk),
        .rst_n         (rst_n),
        .qual_i        (qual_vec),
        .boot_done_i   (boot_done_o),
        .pwr_req_i     (pwr_req_i),
        .fault_clr_i   (fault_clr_i),
        .io_mode_req_i (io_mode_req_i),
        .main_pwr_en_o (main_pwr_en_o),
        .fault_src_o   (fault_src_o),
        .io_mode_o     (io_mode_o)
    );

    // Host flag: any latched source.
    always_comb fault_o = |fault_src_o;

    // The synchronised levels are consumed only through qualification.
    logic unused_sync;
    always_comb unused_sync = ^sync_vec;

endmodule

// File: rtl/tps_checker.sv
// Module: tps_checker
// Port-level properties of the supervisor, attached to the top by bind.
// Assumes: the same synchronous active-low reset as the design.
module tps_checker #(
    parameter int N_SENS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_req_i,
    input logic              fault_clr_i,
    input logic              sensor_init_o,
    input logic              boot_done_o,
    input logic              main_pwr_en_o,
    input logic              fault_o,
    input logic [N_SENS-1:0] fault_src_o,
    input logic              io_mode_o
);
    // Power is never on before boot completes.
    p_no_pwr_before_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done_o |-> !main_pwr_en_o);

    // The sensor programming request lasts one cycle.
    p_init_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_init_o |=> !sensor_init_o);

    // A fresh fault arrives with power already off.
    p_trip_drops_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> !main_pwr_en_o);

    // A latched fault keeps power off.
    p_fault_blocks_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !main_pwr_en_o);

    // Source bits drop only after a host clear.
    p_src_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(fault_src_o) & ~fault_src_o)) |-> $past(fault_clr_i));

    // Power falls within one edge of the host dropping its request.
    p_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_req_i |=> !main_pwr_en_o);

    // The applied I/O level never changes while power was on.
    p_io_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(main_pwr_en_o) |-> $stable(io_mode_o));

endmodule

bind thermal_power_supervisor tps_checker #(.N_SENS(N_SENS)) i_tps_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_req_i     (pwr_req_i),
    .fault_clr_i   (fault_clr_i),
    .sensor_init_o (sensor_init_o),
    .boot_done_o   (boot_done_o),
    .main_pwr_en_o (main_pwr_en_o),
    .fault_o       (fault_o),
    .fault_src_o   (fault_src_o),
    .io_mode_o     (io_mode_o)
);

// File: tb/test_thermal_power_supervisor.sv
module test_thermal_power_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] alert_i;
    logic [7:0] qual_len_i;
    logic       pwr_req_i, fault_clr_i, io_mode_req_i;
    logic       sensor_init_o, boot_done_o, main_pwr_en_o, fault_o, io_mode_o;
    logic [4:0] fault_src_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thermal_power_supervisor i_thermal_power_supervisor (
        .clk(clk), .rst_n(rst_n), .alert_i(alert_i), .qual_len_i(qual_len_i),
        .pwr_req_i(pwr_req_i), .fault_clr_i(fault_clr_i),
        .io_mode_req_i(io_mode_req_i), .sensor_init_o(sensor_init_o),
        .boot_done_o(boot_done_o), .main_pwr_en_o(main_pwr_en_o),
        .fault_o(fault_o), .fault_src_o(fault_src_o), .io_mode_o(io_mode_o)
    );

    // Expected trip decision: the synchronised level needs qual+1 cycles high.
    function automatic bit expect_trip(int len, int q);
        return len >= q + 1;
    endfunction

    function automatic logic [4:0] expect_src(bit trip, int idx);
        return trip ? 5'(1 << idx) : 5'b0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Clear any fault and wait until power is back on.
    task automatic bring_up(string req);
        int t;
        alert_i = '0;
        cyc(4);
        fault_clr_i = 1'b1; cyc(1); fault_clr_i = 1'b0;
        pwr_req_i = 1'b1;
        t = 0;
        while (!main_pwr_en_o && t < 200) begin cyc(1); t++; end
        check(main_pwr_en_o === 1'b1, req, main_pwr_en_o, 1);
    endtask

    // Pulse one sensor and return when the result has settled.
    task automatic pulse(int idx, int len);
        alert_i[idx] = 1'b1; cyc(len); alert_i[idx] = 1'b0;
        cyc(6);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        int pulses, bad, seen_prev, t;
        void'($urandom(32'd4217));
        rst_n = 1'b0; alert_i = '0; qual_len_i = 8'd3;
        pwr_req_i = 1'b1; fault_clr_i = 1'b0; io_mode_req_i = 1'b0;
        cyc(4);
        // R1 reset state
        check({main_pwr_en_o, sensor_init_o, fault_o, io_mode_o, fault_src_o} === 9'b0,
              "R1", {main_pwr_en_o, sensor_init_o, fault_o, io_mode_o, fault_src_o}, 0);

        // R2 boot: one init pulse, no power before boot done
        rst_n = 1'b1;
        pulses = 0; bad = 0; t = 0;
        while (!boot_done_o && t < 200) begin
            cyc(1); t++;
            if (sensor_init_o) pulses++;
            if (!boot_done_o && main_pwr_en_o) bad++;
        end
        check(pulses == 1, "R2 init pulses", pulses, 1);
        check(bad == 0, "R2 power before boot", bad, 0);
        cyc(2);
        check(main_pwr_en_o === 1'b1, "R9 power on when permitted", main_pwr_en_o, 1);

        // R9 host request off and on, one edge each
        pwr_req_i = 1'b0; cyc(1);
        check(main_pwr_en_o === 1'b0, "R9 off latency", main_pwr_en_o, 0);
        pwr_req_i = 1'b1; cyc(1);
        check(main_pwr_en_o === 1'b1, "R9 on latency", main_pwr_en_o, 1);

        // R10 I/O level applied only while power is off (1 = 2.5 V differential)
        io_mode_req_i = 1'b1; cyc(3);
        check(io_mode_o === 1'b0, "R10 held while on", io_mode_o, 0);
        pwr_req_i = 1'b0; cyc(3);
        check(io_mode_o === 1'b1, "R10 follows while off", io_mode_o, 1);
        pwr_req_i = 1'b1; cyc(2);
        io_mode_req_i = 1'b0; cyc(3);
        check(io_mode_o === 1'b1, "R10 held after re-power", io_mode_o, 1);

        // R3 boundary: qual=3, a 3-cycle pulse is ignored
        pulse(0, 3);
        check(fault_src_o === 5'b0, "R3 short pulse src", fault_src_o, 0);
        check(main_pwr_en_o === 1'b1, "R3 short pulse power", main_pwr_en_o, 1);

        // R3/R4: a 4-cycle pulse trips; power falls in the same sample as the flag
        alert_i[0] = 1'b1;
        seen_prev = 1; t = 0;
        while (!fault_o && t < 20) begin seen_prev = main_pwr_en_o; cyc(1); t++; end
        check(fault_o === 1'b1, "R3 long pulse trips", fault_o, 1);
        check(main_pwr_en_o === 1'b0 && seen_prev == 1, "R4 same-edge drop",
              {seen_prev[0], main_pwr_en_o}, 2);
        check(t == 2 + 3 + 1, "R3 qualify cycle", t, 6);
        alert_i[0] = 1'b0; cyc(4);
        check(fault_src_o === 5'b00001, "R5 source bit 0", fault_src_o, 1);

        // R5 accumulate, R6 power blocked while latched
        pulse(3, 8);
        check(fault_src_o === 5'b01001, "R5 accumulate", fault_src_o, 9);
        cyc(40);
        check(main_pwr_en_o === 1'b0, "R6 blocked while latched", main_pwr_en_o, 0);

        // R8 settle: clear right after the alert drops, power waits
        alert_i[1] = 1'b1; cyc(10); alert_i[1] = 1'b0;
        cyc(4);
        fault_clr_i = 1'b1; cyc(1); fault_clr_i = 1'b0;
        check(fault_src_o === 5'b0, "R6 clear", fault_src_o, 0);
        cyc(15);
        check(main_pwr_en_o === 1'b0, "R8 still settling", main_pwr_en_o, 0);
        cyc(SETTLE);
        check(main_pwr_en_o === 1'b1, "R8 on after settle", main_pwr_en_o, 1);

        // R7 clear while sensor 2 remains qualified
        alert_i[2] = 1'b1; cyc(12);
        fault_clr_i = 1'b1; cyc(1); fault_clr_i = 1'b0; cyc(2);
        check(fault_src_o[2] === 1'b1, "R7 bit survives clear", fault_src_o, 4);
        check(main_pwr_en_o === 1'b0, "R7 power stays off", main_pwr_en_o, 0);
        alert_i[2] = 1'b0; cyc(4);
        fault_clr_i = 1'b1; cyc(1); fault_clr_i = 1'b0; cyc(1);
        check(fault_src_o === 5'b0, "R7 later clear empties", fault_src_o, 0);

        // Random pulses around the threshold (R3, R5)
        for (int it = 0; it < 24; it++) begin
            int q, len, idx;
            bit trip;
            q   = int'($urandom_range(0, 6));
            idx = int'($urandom_range(0, 4));
            len = int'($urandom_range(1, q + 3));
            qual_len_i = 8'(q);
            bring_up("R9 bring-up");
            pulse(idx, len);
            trip = expect_trip(len, q);
            check(fault_src_o === expect_src(trip, idx), "R3 random src",
                  fault_src_o, expect_src(trip, idx));
            check(main_pwr_en_o === !trip, "R4 random power", main_pwr_en_o, !trip);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule